// File: doc/BRIEF.md
# Section Parity (B1) Error Monitor

This block checks section-level parity on a received SONET/SDH byte stream. Every covered byte of a frame is folded into an 8-column even-parity word. When the next frame starts, that word is held as the reference. The byte flagged as B1 in that next frame is then compared against it, column by column. The result adds to an internal error accumulator. Some bytes are not covered: the framing bytes and the trace/growth byte. An external flag marks them, and those bytes never enter the parity word.

The surrounding framer supplies the byte stream and all position information. This includes a pulse on the first byte of each frame, a flag for excluded bytes, and a flag for the B1 byte. A framing-mode input selects STS-3/STM-1 or STS-1 operation. Any change of this input discards the stored frame history, because the frame layout changes with it. The count policy has two selectable parts:
- The unit counted: individual mismatching bits, or whole frames that have any mismatch.
- The overflow behaviour: saturate, or wrap.

A performance-monitoring strobe copies the accumulator into the visible counter and restarts the accumulator from zero.

Top module: `b1_bip8_monitor`

## Requirements
- R1: The parity word of a frame is the even parity of every column over all valid, non-excluded bytes from the frame-start byte up to the next frame start, B1 byte included. A B1 byte equal to the previous frame's parity word adds zero errors.
- R2: Bytes with `skipByte` high leave the parity word unchanged, whatever their value.
- R3: With `blockMode` = 0, a compare adds the number of 1 bits in (B1 byte XOR previous parity word), from 0 to 8.
- R4: With `blockMode` = 1, a compare adds 1 if that XOR is nonzero and 0 otherwise.
- R5: No compare takes place in the first frame after reset or after any cycle with `lossOfFrame` high. Compares resume in the second frame that starts after reset or after the last loss cycle.
- R6: A change of `sts1Mode` (0 = STS-3/STM-1, 1 = STS-1) has the same effect on the history as a loss of frame.
- R7: After reset, `errCount` is 0. On a cycle with `pmStrobe` high, `errCount` takes the accumulator value and the accumulator restarts at zero. Otherwise `errCount` holds its value.
- R8: An increment in the same cycle as `pmStrobe` is not lost. It becomes the first content of the restarted accumulator and is not part of the transferred value.
- R9: With `satMode` = 1, the accumulator stops at all ones (2^CNT_W−1).
- R10: With `satMode` = 0, the accumulator wraps modulo 2^CNT_W.
- R11: Only the first `b1Flag` byte of a frame is compared. Later flagged bytes in the same frame add nothing.
- R12: The parity word restarts at each frame start. Bytes of an earlier frame do not affect it.
- R13: Cycles with `dataValid` low change neither the parity word nor the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | DATA_W | Received byte, as scrambled on the line |
| dataValid | input | 1 | dataIn carries a frame byte this cycle |
| frameStart | input | 1 | Byte is the first byte of a frame |
| skipByte | input | 1 | Byte is excluded from parity |
| b1Flag | input | 1 | Byte is the B1 parity byte |
| lossOfFrame | input | 1 | Framer has lost alignment; history discarded |
| sts1Mode | input | 1 | 0 = STS-3/STM-1 framing, 1 = STS-1 framing |
| blockMode | input | 1 | 0 = count bits, 1 = count errored frames |
| satMode | input | 1 | 1 = saturate on overflow, 0 = wrap |
| pmStrobe | input | 1 | Transfer accumulator to errCount and clear it |
| errCount | output | CNT_W | Error count latched at the last pmStrobe |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 8. The narrow counter means overflow needs only 32 fully errored frames in bit mode, so both the saturating and the wrapping policy are checked in a few hundred cycles. The frames are short, with a single excluded byte, so the loss-of-frame and mode-change recovery sequences are also short. The bench runs them several times between randomly mixed masks, gaps and count modes.

// File: rtl/b1mon_pkg.sv
package b1mon_pkg;

  // Per-byte strobes from the frame control to the parity datapath.
  typedef struct packed {
    logic frameOpen;   // restart parity word with this byte
    logic addByte;     // byte is valid and covered
    logic latchPrev;   // keep finished frame parity as reference
    logic doCompare;   // this byte is the B1 to be checked
    logic clearAcc;    // transfer accumulator and restart it
  } b1Strobes_t;

endpackage

// File: rtl/b1mon_ctrl.sv
module b1mon_ctrl
  import b1mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataValid,
  input  logic       frameStart,
  input  logic       skipByte,
  input  logic       b1Flag,
  input  logic       lossOfFrame,
  input  logic       sts1Mode,
  input  logic       pmStrobe,
  output b1Strobes_t strobes
);

  logic frameSeen;  // at least one frame has been opened since history loss
  logic havePrev;   // a complete previous frame parity is held
  logic b1Done;     // B1 already compared in current frame
  logic modeQ;
  logic modeChg;
  logic dropHist;

  assign modeChg  = sts1Mode != modeQ;
  assign dropHist = lossOfFrame | modeChg;

  always_comb begin
    strobes.frameOpen = dataValid & frameStart & ~dropHist;
    strobes.addByte   = dataValid & ~skipByte;
    strobes.latchPrev = dataValid & frameStart & ~dropHist & frameSeen;
    strobes.doCompare = dataValid & b1Flag & ~frameStart & havePrev
                        & ~b1Done & ~dropHist;
    strobes.clearAcc  = pmStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSeen <= 1'b0;
      havePrev  <= 1'b0;
      b1Done    <= 1'b0;
      modeQ     <= 1'b0;
    end else begin
      modeQ <= sts1Mode;
      if (dropHist) begin
        frameSeen <= 1'b0;
        havePrev  <= 1'b0;
        b1Done    <= 1'b0;
      end else if (strobes.frameOpen) begin
        frameSeen <= 1'b1;
        havePrev  <= frameSeen;
        b1Done    <= 1'b0;
      end else if (strobes.doCompare) begin
        b1Done <= 1'b1;
      end
    end
  end

  // R5: loss of frame wipes the history
  a_r5_lof_clears: assert property (@(posedge clk) disable iff (!rstN)
    lossOfFrame |=> (!havePrev && !frameSeen));

  // R5: a compare needs an opened frame behind it
  a_r5_compare_history: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doCompare |-> frameSeen);

  // R11: after a compare the frame is marked done
  a_r11_single_compare: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doCompare |=> (b1Done || !frameSeen));

  // R6: a mode change drops the history in the next cycle
  a_r6_mode_drop: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> !havePrev);

endmodule

// File: rtl/b1mon_dp.sv
module b1mon_dp
  import b1mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              blockMode,
  input  logic              satMode,
  input  b1Strobes_t        strobes,
  output logic [CNT_W-1:0]  errCount
);

  localparam int INC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] curPar;
  logic [DATA_W-1:0] prevPar;
  logic [DATA_W-1:0] mism;
  logic [INC_W-1:0]  bitCnt;
  logic [INC_W-1:0]  incVal;
  logic [CNT_W-1:0]  accQ;
  logic [CNT_W-1:0]  baseAcc;
  logic [CNT_W:0]    sumExt;
  logic [CNT_W-1:0]  accNext;

  always_comb begin
    mism   = dataIn ^ prevPar;
    bitCnt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      bitCnt = bitCnt + INC_W'(mism[i]);
    end
    if (!strobes.doCompare)
      incVal = '0;
    else if (blockMode)
      incVal = INC_W'(|mism);
    else
      incVal = bitCnt;
  end

  always_comb begin
    baseAcc = strobes.clearAcc ? '0 : accQ;
    sumExt  = {1'b0, baseAcc} + (CNT_W + 1)'(incVal);
    if (sumExt[CNT_W] && satMode)
      accNext = '1;
    else
      accNext = sumExt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPar   <= '0;
      prevPar  <= '0;
      accQ     <= '0;
      errCount <= '0;
    end else begin
      if (strobes.latchPrev)
        prevPar <= curPar;
      if (strobes.frameOpen)
        curPar <= strobes.addByte ? dataIn : '0;
      else if (strobes.addByte)
        curPar <= curPar ^ dataIn;
      accQ <= accNext;
      if (strobes.clearAcc)
        errCount <= accQ;
    end
  end

  // R9: a saturated accumulator stays saturated
  a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (satMode && accQ == {CNT_W{1'b1}} && !strobes.clearAcc) |=> accQ == {CNT_W{1'b1}});

  // R7: transfer takes the pre-clear accumulator
  a_r7_transfer: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> errCount == $past(accQ));

  // R7: counter holds between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAcc |=> $stable(errCount));

  // R13: no compare and no strobe leaves the accumulator alone
  a_r13_acc_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doCompare && !strobes.clearAcc) |=> $stable(accQ));

  // R4: block mode never adds more than one
  a_r4_block_single: assert property (@(posedge clk) disable iff (!rstN)
    blockMode |-> incVal <= INC_W'(1));

endmodule

// File: rtl/b1_bip8_monitor.sv
module b1_bip8_monitor
  import b1mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic              frameStart,
  input  logic              skipByte,
  input  logic              b1Flag,
  input  logic              lossOfFrame,
  input  logic              sts1Mode,
  input  logic              blockMode,
  input  logic              satMode,
  input  logic              pmStrobe,
  output logic [CNT_W-1:0]  errCount
);

  b1Strobes_t strobes;

  b1mon_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .dataValid  (dataValid),
    .frameStart (frameStart),
    .skipByte   (skipByte),
    .b1Flag     (b1Flag),
    .lossOfFrame(lossOfFrame),
    .sts1Mode   (sts1Mode),
    .pmStrobe   (pmStrobe),
    .strobes    (strobes)
  );

  b1mon_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .blockMode(blockMode),
    .satMode  (satMode),
    .strobes  (strobes),
    .errCount (errCount)
  );

endmodule

// File: tb/tb_b1_bip8_monitor.sv
`timescale 1ns/1ps
module tb_b1_bip8_monitor;

  localparam int TB_CNT_W = 8;
  localparam int MAXV = (1 << TB_CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic dataValid = 0, frameStart = 0, skipByte = 0, b1Flag = 0;
  logic lossOfFrame = 0, sts1Mode = 0, blockMode = 0, satMode = 1, pmStrobe = 0;
  logic [TB_CNT_W-1:0] errCount;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // bench reference state
  logic [7:0] mCur = '0, mPrev = '0;
  bit mSeen = 0, mHave = 0, mDone = 0, mModeQ = 0;
  int mAcc = 0, mCnt = 0;

  always #2 clk = ~clk;

  b1_bip8_monitor #(.DATA_W(8), .CNT_W(TB_CNT_W)) dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid),
    .frameStart(frameStart), .skipByte(skipByte), .b1Flag(b1Flag),
    .lossOfFrame(lossOfFrame), .sts1Mode(sts1Mode), .blockMode(blockMode),
    .satMode(satMode), .pmStrobe(pmStrobe), .errCount(errCount)
  );

  function automatic int popc(input logic [7:0] x);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(x[i]);
    return n;
  endfunction

  function automatic int addSat(input int base, input int inc, input bit sat);
    int s = base + inc;
    if (s > MAXV) return sat ? MAXV : (s & MAXV);
    return s;
  endfunction

  task automatic modelStep(input logic [7:0] d, input bit fs, sk, b1, v, pm);
    bit drop = lossOfFrame || (sts1Mode != mModeQ);
    bit cmp  = v && b1 && !fs && mHave && !mDone && !drop;
    int inc  = 0;
    if (cmp) inc = blockMode ? int'((d ^ mPrev) != 0) : popc(d ^ mPrev);
    if (pm) begin
      mCnt = mAcc;
      mAcc = addSat(0, inc, satMode);
    end else begin
      mAcc = addSat(mAcc, inc, satMode);
    end
    if (v && fs && !drop) begin
      if (mSeen) mPrev = mCur;
      mCur  = sk ? 8'h00 : d;
      mHave = mSeen;
      mSeen = 1;
      mDone = 0;
    end else if (v && !sk) begin
      mCur = mCur ^ d;
    end
    if (cmp) mDone = 1;
    if (drop) begin mSeen = 0; mHave = 0; mDone = 0; end
    mModeQ = sts1Mode;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit fs, sk, b1, v, pm);
    @(negedge clk);
    dataIn = d; frameStart = fs; skipByte = sk; b1Flag = b1;
    dataValid = v; pmStrobe = pm;
    @(posedge clk);
    modelStep(d, fs, sk, b1, v, pm);
    #1;
    frameStart = 0; b1Flag = 0; pmStrobe = 0; dataValid = 0;
  endtask

  task automatic sendFrame(input logic [7:0] mask, input int nBody,
                           input bit twoB1, input bit pmOnB1);
    sendByte(8'($urandom), 1, 0, 0, 1, 0);
    sendByte(8'($urandom), 0, 1, 0, 1, 0);        // excluded byte
    sendByte(mPrev ^ mask, 0, 0, 1, 1, pmOnB1);   // B1
    if (twoB1) sendByte(8'($urandom), 0, 0, 1, 1, 0);
    for (int i = 0; i < nBody; i++) begin
      if ($urandom % 4 == 0) sendByte(8'($urandom), 0, 0, 0, 0, 0); // gap
      sendByte(8'($urandom), 0, ($urandom % 6 == 0), 0, 1, 0);
    end
  endtask

  task automatic pulsePm();
    sendByte(8'($urandom), 0, 0, 0, 0, 1);
  endtask

  task automatic checkEq(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: errCount actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1;
    checkEq(int'(errCount), 0, "R7 reset");
    rstN = 1;

    // R5: first frame after reset has no reference, even with a bad B1
    sendFrame(8'hFF, 3, 0, 0);
    sendFrame(8'h00, 3, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 0, "R5 first frame after reset");

    // R1 R2 R12 R13: clean frames with gaps and excluded bytes
    for (int f = 0; f < 4; f++) sendFrame(8'h00, 5, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 0, "R1 R2 R12 R13 clean frames");

    // R3: bit mode, two bits per frame
    for (int f = 0; f < 3; f++) sendFrame(8'h05, 4, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 6, "R3 bit count");

    // R4: block mode
    blockMode = 1;
    sendFrame(8'hFF, 2, 0, 0);
    sendFrame(8'h01, 2, 0, 0);
    sendFrame(8'h80, 2, 0, 0);
    sendFrame(8'h00, 2, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 3, "R4 block count");
    blockMode = 0;

    // R11: a second flagged byte in a frame is ignored
    sendFrame(8'h00, 3, 1, 0);
    sendFrame(8'h00, 3, 1, 0);
    pulsePm();
    checkEq(int'(errCount), 0, "R11 second B1 ignored");

    // R5: loss of frame
    lossOfFrame = 1;
    sendByte(8'h00, 0, 0, 0, 0, 0);
    lossOfFrame = 0;
    sendFrame(8'hFF, 3, 0, 0);
    sendFrame(8'h0F, 3, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 4, "R5 resume after loss of frame");

    // R6: framing-mode change drops the history
    sts1Mode = 1;
    sendFrame(8'hFF, 3, 0, 0);
    sendFrame(8'hFF, 3, 0, 0);
    sendFrame(8'h03, 3, 0, 0);
    pulsePm();
    checkEq(int'(errCount), 2, "R6 mode change");

    // R8: strobe on the B1 byte
    sendFrame(8'h03, 2, 0, 0);
    sendFrame(8'h30, 2, 0, 1);
    checkEq(int'(errCount), 2, "R8 transfer excludes same-cycle increment");
    pulsePm();
    checkEq(int'(errCount), 2, "R8 same-cycle increment kept");

    // R9: saturation
    satMode = 1;
    for (int f = 0; f < 40; f++) sendFrame(8'hFF, 1, 0, 0);
    pulsePm();
    checkEq(int'(errCount), MAXV, "R9 saturate");

    // R10: wrap
    satMode = 0;
    for (int f = 0; f < 40; f++) sendFrame(8'hFF, 1, 0, 0);
    pulsePm();
    checkEq(int'(errCount), (40 * 8) % (MAXV + 1), "R10 wrap");

    // R7: holds without a strobe, R13 invalid noise
    for (int f = 0; f < 3; f++) sendFrame(8'hAA, 2, 0, 0);
    for (int i = 0; i < 5; i++) sendByte(8'($urandom), 1, 0, 1, 0, 0);
    checkEq(int'(errCount), (40 * 8) % (MAXV + 1), "R7 hold R13 invalid");
    pulsePm();
    checkEq(int'(errCount), 12, "R13 invalid bytes add nothing");

    // random phase against the reference model
    satMode = 1;
    for (int f = 0; f < 150; f++) begin
      logic [7:0] mk;
      mk = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      if ($urandom % 20 == 0) blockMode = ~blockMode;
      if ($urandom % 37 == 0) begin
        lossOfFrame = 1; sendByte(8'h00, 0, 0, 0, 0, 0); lossOfFrame = 0;
      end
      sendFrame(mk, 1 + ($urandom % 5), ($urandom % 8 == 0), ($urandom % 15 == 0));
      if (f % 10 == 9) begin
        pulsePm();
        checkEq(int'(errCount), mCnt, "R3 R4 R12 random");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule